// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block brings an external 10/100 Ethernet PHY from power-on to a negotiated link without software. After a single-cycle start pulse it drives a management-register request port, which is served by a serial management controller. The sequence it runs is fixed. First it sets the PHY's soft-reset bit and waits for the PHY to clear it. Next it writes the advertisement register so that all four 10/100 half/full modes are offered. It then enables and restarts auto-negotiation and waits for the completion flag. Last, it takes one more status read and resolves the link speed and duplex from the capability bits found there.

The two waiting phases poll the PHY. Each has its own retry budget, and a failed poll is followed by a fixed idle gap before the next attempt. When the sequence ends the block shows either a completion flag with the resolved speed and duplex, or an error flag with a cause code. These results stay unchanged until the next start is accepted. Only one management request is outstanding at any time.

Top module: `phy_bringup_seq`

## Requirements
- R1: During and after reset the block is idle: `busy`, `mgmt_req`, `done`, `error`, `speed100` and `full_duplex` are 0, and `err_cause` is 2'b00.
- R2: A start pulse seen while idle clears `done`, `error`, `err_cause`, `speed100` and `full_duplex` and raises `busy` on the next cycle. In that same cycle it issues the first request, a write (`mgmt_write`=1) of 16'h8000 to register 0.
- R3: After that write the block reads register 0 (`mgmt_write`=0) until a read returns bit 15 clear. If RESET_TRIES reads all return bit 15 set, it stops with `error`=1 and `err_cause`=2'b01.
- R4: After a poll read fails but retries remain, the next request comes exactly 1+POLL_DELAY cycles after the cycle in which `mgmt_done` was high. Every other next request comes in the cycle right after `mgmt_done`, and the first request comes in the cycle right after the accepted start.
- R5: Once the reset bit reads clear, the block writes 16'h01E1 to register 4 and then 16'h1200 to register 0.
- R6: Next it reads register 1 until a read returns bit 5 set. If AN_TRIES reads all return bit 5 clear, it stops with `error`=1 and `err_cause`=2'b10.
- R7: After auto-negotiation completes, one further read of register 1 ends the sequence in the cycle after its `mgmt_done`. At that point `done`=1, `error`=0 and `err_cause`=2'b00. `speed100` is set when bit 14 or bit 13 of that read is set, and `full_duplex` is set when bit 14 or bit 12 is set. After a timeout `speed100` and `full_duplex` stay 0.
- R8: `mgmt_req` is high for exactly one cycle per request. No new request is issued until `mgmt_done` has answered the previous one.
- R9: A start pulse while `busy` is 1 has no effect. This includes the cycle in which the final `mgmt_done` arrives: the running sequence, its requests and its results are unchanged.
- R10: While the block is idle and no start is given, `done`, `error`, `err_cause`, `speed100` and `full_duplex` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to run the bring-up sequence |
| mgmt_req | output | 1 | One-cycle pulse issuing a management request |
| mgmt_write | output | 1 | 1 = register write, 0 = register read |
| mgmt_reg | output | 5 | PHY register address of the request |
| mgmt_wdata | output | 16 | Data for a write request |
| mgmt_done | input | 1 | One-cycle completion of the outstanding request |
| mgmt_rdata | input | 16 | Read data, valid with `mgmt_done` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished with a negotiated link |
| error | output | 1 | Sequence stopped on a timeout |
| err_cause | output | 2 | 01 reset timeout, 10 negotiation timeout, 00 none |
| speed100 | output | 1 | Resolved speed is 100 Mb/s (else 10 Mb/s) |
| full_duplex | output | 1 | Resolved duplex is full (else half) |

## Verification
A start pulse can fall in the same cycle as the management completion that ends the sequence. That cycle still counts as busy, so the start must be lost and must not re-arm the sequencer. The bench provokes this by having its PHY responder raise `start` in the very cycle it drives the final `mgmt_done`. It then checks that the results appear on time, that no further request appears, and that the outputs keep their values while idle. A second ignored start is placed in the middle of a running sequence, and the bench checks that the expected request stream continues unchanged.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_RST  = 2'b01;
  localparam logic [1:0] CAUSE_AN   = 2'b10;

  localparam logic [DATA_W-1:0] CTRL_SOFT_RESET = 16'h8000;
  localparam logic [DATA_W-1:0] ADV_10_100_ALL  = 16'h01E1;
  localparam logic [DATA_W-1:0] CTRL_AN_RESTART = 16'h1200;

  localparam logic [REG_W-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_W-1:0] REG_STAT = 5'd1;
  localparam logic [REG_W-1:0] REG_ADV  = 5'd4;

  localparam int BIT_RESET_BUSY = 15;
  localparam int BIT_AN_DONE    = 5;
  localparam int BIT_100_FD     = 14;
  localparam int BIT_100_HD     = 13;
  localparam int BIT_10_FD      = 12;

  typedef enum logic [2:0] {
    STEP_RST_WR, STEP_RST_POLL, STEP_ADV_WR, STEP_AN_WR, STEP_AN_POLL, STEP_STAT_RD
  } step_e;

  typedef enum logic [1:0] {
    FSM_IDLE, FSM_ISSUE, FSM_WAIT, FSM_DELAY
  } fsm_e;

  typedef struct packed {
    logic              write;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t step_cmd(step_e s);
    mgmt_cmd_t c;
    case (s)
      STEP_RST_WR:   c = '{write: 1'b1, regad: REG_CTRL, data: CTRL_SOFT_RESET};
      STEP_RST_POLL: c = '{write: 1'b0, regad: REG_CTRL, data: '0};
      STEP_ADV_WR:   c = '{write: 1'b1, regad: REG_ADV,  data: ADV_10_100_ALL};
      STEP_AN_WR:    c = '{write: 1'b1, regad: REG_CTRL, data: CTRL_AN_RESTART};
      default:       c = '{write: 1'b0, regad: REG_STAT, data: '0};
    endcase
    return c;
  endfunction

  function automatic step_e step_next(step_e s);
    case (s)
      STEP_RST_WR:   return STEP_RST_POLL;
      STEP_RST_POLL: return STEP_ADV_WR;
      STEP_ADV_WR:   return STEP_AN_WR;
      STEP_AN_WR:    return STEP_AN_POLL;
      STEP_AN_POLL:  return STEP_STAT_RD;
      default:       return STEP_RST_WR;
    endcase
  endfunction

  function automatic logic step_ok(step_e s, logic [DATA_W-1:0] rd);
    case (s)
      STEP_RST_POLL: return !rd[BIT_RESET_BUSY];
      STEP_AN_POLL:  return rd[BIT_AN_DONE];
      default:       return 1'b1;
    endcase
  endfunction

  function automatic logic res_speed100(logic [DATA_W-1:0] st);
    return st[BIT_100_FD] | st[BIT_100_HD];
  endfunction

  function automatic logic res_full(logic [DATA_W-1:0] st);
    return st[BIT_100_FD] | st[BIT_10_FD];
  endfunction

endpackage

// File: rtl/phy_seq_delay.sv
module phy_seq_delay #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);

  a_r4_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire)
    else $error("R4: delay expired twice in a row");

endmodule

// File: rtl/phy_seq_tries.sv
module phy_seq_tries #(
  parameter int unsigned MAX_TRIES = 100,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [TW-1:0] limit,
  output logic          last
);
  logic [TW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign last = (count == limit - TW'(1));

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TW'(MAX_TRIES))
    else $error("R6: retry count beyond budget");

endmodule

// File: rtl/phy_seq_resolve.sv
module phy_seq_resolve
  import phy_seq_pkg::*;
(
  input  logic [DATA_W-1:0] status,
  output logic              speed100,
  output logic              full
);
  assign speed100 = res_speed100(status);
  assign full     = res_full(status);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned POLL_DELAY  = 50000,
  parameter int unsigned RESET_TRIES = 10,
  parameter int unsigned AN_TRIES    = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        mgmt_req,
  output logic        mgmt_write,
  output logic [4:0]  mgmt_reg,
  output logic [15:0] mgmt_wdata,
  input  logic        mgmt_done,
  input  logic [15:0] mgmt_rdata,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [1:0]  err_cause,
  output logic        speed100,
  output logic        full_duplex
);
  localparam int unsigned MAX_TRIES = (RESET_TRIES > AN_TRIES) ? RESET_TRIES : AN_TRIES;
  localparam int TW = $clog2(MAX_TRIES + 1);

  fsm_e      state;
  step_e     step;
  mgmt_cmd_t cmd;

  // named events
  logic accept, resp, resp_ok, resp_fail, tries_last, timeout_ev, retry_ev, finish_ok, dly_expire;
  logic          res_spd, res_fd;
  logic [TW-1:0] limit;

  assign cmd        = step_cmd(step);
  assign mgmt_req   = (state == FSM_ISSUE);
  assign mgmt_write = cmd.write;
  assign mgmt_reg   = cmd.regad;
  assign mgmt_wdata = cmd.data;
  assign busy       = (state != FSM_IDLE);

  assign accept     = start && (state == FSM_IDLE);
  assign resp       = (state == FSM_WAIT) && mgmt_done;
  assign resp_ok    = resp && step_ok(step, mgmt_rdata);
  assign resp_fail  = resp && !step_ok(step, mgmt_rdata);
  assign timeout_ev = resp_fail && tries_last;
  assign retry_ev   = resp_fail && !tries_last;
  assign finish_ok  = resp_ok && (step == STEP_STAT_RD);
  assign limit      = (step == STEP_RST_POLL) ? TW'(RESET_TRIES) : TW'(AN_TRIES);

  phy_seq_delay #(.CYCLES(POLL_DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(retry_ev), .expire(dly_expire));

  phy_seq_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(accept || resp_ok), .inc(retry_ev),
    .limit(limit), .last(tries_last));

  phy_seq_resolve u_resolve (
    .status(mgmt_rdata), .speed100(res_spd), .full(res_fd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FSM_IDLE;
      step  <= STEP_RST_WR;
    end else begin
      case (state)
        FSM_IDLE: if (accept) begin
          state <= FSM_ISSUE;
          step  <= STEP_RST_WR;
        end
        FSM_ISSUE: state <= FSM_WAIT;
        FSM_WAIT: begin
          if (finish_ok || timeout_ev) state <= FSM_IDLE;
          else if (resp_ok) begin
            state <= FSM_ISSUE;
            step  <= step_next(step);
          end else if (retry_ev) state <= FSM_DELAY;
        end
        default: if (dly_expire) state <= FSM_ISSUE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      error       <= 1'b0;
      err_cause   <= CAUSE_NONE;
      speed100    <= 1'b0;
      full_duplex <= 1'b0;
    end else if (accept) begin
      done        <= 1'b0;
      error       <= 1'b0;
      err_cause   <= CAUSE_NONE;
      speed100    <= 1'b0;
      full_duplex <= 1'b0;
    end else if (finish_ok) begin
      done        <= 1'b1;
      speed100    <= res_spd;
      full_duplex <= res_fd;
    end else if (timeout_ev) begin
      error     <= 1'b1;
      err_cause <= (step == STEP_RST_POLL) ? CAUSE_RST : CAUSE_AN;
    end
  end

  a_r2_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mgmt_req && mgmt_write && mgmt_reg == REG_CTRL && mgmt_wdata == CTRL_SOFT_RESET)
    else $error("R2: first request is not the soft reset write");

  a_r3_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (error == (err_cause != CAUSE_NONE)) && err_cause != 2'b11)
    else $error("R3: error flag and cause disagree");

  a_r5_write_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_write) |-> (mgmt_reg == REG_CTRL || mgmt_reg == REG_ADV))
    else $error("R5: write to unexpected register");

  a_r6_read_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !mgmt_write) |-> (mgmt_reg == REG_CTRL || mgmt_reg == REG_STAT))
    else $error("R6: read of unexpected register");

  a_r7_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && !error)
    else $error("R7: completion with error or still busy");

  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |=> !mgmt_req)
    else $error("R8: request longer than one cycle");

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({done, error, err_cause, speed100, full_duplex}))
    else $error("R10: results changed while idle");

endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PD = 3;
  localparam int RT = 10;
  localparam int AT = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mgmt_req, mgmt_write;
  logic [4:0]  mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic mgmt_done = 1'b0;
  logic [15:0] mgmt_rdata = '0;
  logic busy, done, error, speed100, full_duplex;
  logic [1:0] err_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_bringup_seq #(.POLL_DELAY(PD), .RESET_TRIES(RT), .AN_TRIES(AT)) i_phy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mgmt_req(mgmt_req), .mgmt_write(mgmt_write), .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
    .mgmt_done(mgmt_done), .mgmt_rdata(mgmt_rdata),
    .busy(busy), .done(done), .error(error), .err_cause(err_cause),
    .speed100(speed100), .full_duplex(full_duplex));

  typedef struct {bit wr; int rg; int dat; int gap; bit last;} xact_t;
  xact_t exp_q[$];

  int n_checks = 0, n_err = 0, cyc = 0, last_evt = 0;
  // reference model state
  bit exp_busy = 0, exp_done = 0, exp_error = 0, exp_spd = 0, exp_fd = 0;
  int exp_cause = 0;
  bit res_done, res_error, res_spd, res_fd;
  int res_cause;
  bit pend_start = 0, pend_end = 0, want_start = 0;
  // responder state
  bit outstanding = 0, cur_last = 0, cur_wr = 0;
  int cur_reg = 0, resp_cnt = 0, r0_reads = 0, r1_reads = 0;
  // scenario config
  int cfg_rb, cfg_ab, cfg_lat;
  logic [15:0] cfg_stat;
  bit cfg_coincide = 0;

  task automatic chk(bit ok, string tag, int act, int expv, string what);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic void push(bit wr, int rg, int dat, int gap, bit last);
    xact_t e;
    e.wr = wr; e.rg = rg; e.dat = dat; e.gap = gap; e.last = last;
    exp_q.push_back(e);
  endfunction

  // expected request stream and results, derived from the requirements
  function automatic void build_expect();
    int nr, na;
    exp_q.delete();
    res_done = 0; res_error = 0; res_cause = 0; res_spd = 0; res_fd = 0;
    push(1, 0, 'h8000, 1, 0);
    nr = (cfg_rb + 1 < RT) ? cfg_rb + 1 : RT;
    for (int i = 0; i < nr; i++)
      push(0, 0, 0, (i == 0) ? 1 : 1 + PD, (cfg_rb >= RT) && (i == nr - 1));
    if (cfg_rb >= RT) begin
      res_error = 1; res_cause = 1;
      return;
    end
    push(1, 4, 'h01E1, 1, 0);
    push(1, 0, 'h1200, 1, 0);
    na = (cfg_ab + 1 < AT) ? cfg_ab + 1 : AT;
    for (int i = 0; i < na; i++)
      push(0, 1, 0, (i == 0) ? 1 : 1 + PD, (cfg_ab >= AT) && (i == na - 1));
    if (cfg_ab >= AT) begin
      res_error = 1; res_cause = 2;
      return;
    end
    push(0, 1, 0, 1, 1);
    res_done = 1;
    res_spd = cfg_stat[14] | cfg_stat[13];
    res_fd  = cfg_stat[14] | cfg_stat[12];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (pend_start) begin
        exp_busy = 1; exp_done = 0; exp_error = 0; exp_cause = 0; exp_spd = 0; exp_fd = 0;
        pend_start = 0;
      end
      if (pend_end) begin
        exp_busy = 0; exp_done = res_done; exp_error = res_error; exp_cause = res_cause;
        exp_spd = res_spd; exp_fd = res_fd;
        pend_end = 0;
      end
      // per-cycle comparison against the model
      chk(busy == exp_busy, "R2", busy, exp_busy, "busy");
      chk(done == exp_done, exp_busy ? "R7" : "R10", done, exp_done, "done");
      chk(error == exp_error, exp_busy ? "R3" : "R10", error, exp_error, "error");
      chk(err_cause == 2'(exp_cause), "R6", err_cause, exp_cause, "err_cause");
      chk(speed100 == exp_spd, "R7", speed100, exp_spd, "speed100");
      chk(full_duplex == exp_fd, "R7", full_duplex, exp_fd, "full_duplex");

      mgmt_done = 0;
      start = 0;

      // PHY responder
      if (outstanding) begin
        resp_cnt--;
        if (resp_cnt == 0) begin
          mgmt_done = 1;
          mgmt_rdata = 16'h0000;
          if (!cur_wr && cur_reg == 0) begin
            mgmt_rdata = (r0_reads < cfg_rb) ? 16'h9100 : 16'h1100;
            r0_reads++;
          end else if (!cur_wr && cur_reg == 1) begin
            mgmt_rdata = (cfg_stat & 16'h7000) | 16'h0009;
            if (r1_reads >= cfg_ab) mgmt_rdata[5] = 1'b1;
            r1_reads++;
          end
          outstanding = 0;
          last_evt = cyc;
          if (cur_last) begin
            pend_end = 1;
            if (cfg_coincide) want_start = 1;  // R9: start in the final-completion cycle
          end
        end
      end

      // request observation
      if (mgmt_req) begin
        chk(!outstanding, "R8", 1, 0, "request while one is outstanding");
        if (exp_q.size() == 0) begin
          chk(0, "R9", 1, 0, "request with no sequence running");
        end else begin
          xact_t e;
          e = exp_q.pop_front();
          chk(mgmt_write == e.wr, e.rg == 4 ? "R5" : "R3", mgmt_write, e.wr, "write flag");
          chk(int'(mgmt_reg) == e.rg, e.rg == 1 ? "R6" : "R5", mgmt_reg, e.rg, "register");
          if (e.wr) chk(int'(mgmt_wdata) == e.dat, "R5", mgmt_wdata, e.dat, "write data");
          chk(cyc - last_evt == e.gap, "R4", cyc - last_evt, e.gap, "request spacing");
          cur_last = e.last; cur_wr = e.wr; cur_reg = e.rg;
        end
        outstanding = 1;
        resp_cnt = cfg_lat;
      end

      if (want_start) begin
        start = 1;
        want_start = 0;
        if (!exp_busy) begin
          pend_start = 1;
          last_evt = cyc;
          r0_reads = 0; r1_reads = 0;
          build_expect();
        end
      end
    end
  end

  task automatic run_scn(int rb, int ab, logic [15:0] st, int lat, int mid, bit coincide);
    cfg_rb = rb; cfg_ab = ab; cfg_stat = st; cfg_lat = lat; cfg_coincide = coincide;
    want_start = 1;
    @(negedge clk);
    @(negedge clk);
    if (mid > 0) begin
      repeat (mid) @(negedge clk);
      want_start = 1;  // R9: ignored mid-sequence start
    end
    while (exp_busy || pend_start || pend_end || want_start) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0, "unissued requests left");
    chk(done == res_done, "R7", done, res_done, "final done");
    chk(int'(err_cause) == res_cause, res_cause == 1 ? "R3" : "R6", err_cause, res_cause, "final cause");
    chk(speed100 == res_spd && full_duplex == res_fd, "R7",
        {speed100, full_duplex}, {res_spd, res_fd}, "final speed/duplex");
    cfg_coincide = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mgmt_req, "R1", {busy, mgmt_req}, 0, "idle in reset");
    chk(!done && !error && err_cause == 0 && !speed100 && !full_duplex, "R1",
        {done, error, err_cause, speed100, full_duplex}, 0, "results in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !mgmt_req, "R1", {busy, mgmt_req}, 0, "idle after reset");
    run_scn(0, 0, 16'h7800, 1, 0, 0);    // 100 full
    run_scn(3, 5, 16'h2000, 3, 0, 0);    // 100 half
    run_scn(RT - 1, AT - 1, 16'h1000, 1, 0, 0); // last-try success, 10 full
    run_scn(RT, 0, 16'h7800, 2, 0, 0);   // R3 reset timeout
    run_scn(1, AT, 16'h7800, 1, 0, 0);   // R6 negotiation timeout
    run_scn(2, 2, 16'h0000, 2, 20, 1);   // 10 half, ignored starts
    run_scn(0, 1, 16'h4000, 1, 0, 0);    // bit 14 alone
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule